// File: doc/BRIEF.md
# Indirect Register Port with Interrupt Pending and Enable

This block is the host-facing register front end of an audio controller. The host sees four 32-bit words. A pointer word holds a register index and a channel number. A data word then reads or writes the internal bank entry that the pointer selects. A pending word collects interrupt events, and an enable word selects which pending bits drive the single interrupt request line.

The internal bank is addressed by the pair (index, channel). The pointer keeps its index field in bits 27:16 and its channel field in bits 1:0, so a write with byte enables can update one field and leave the other alone. Event strobes from neighbouring blocks set pending bits. The host clears them by writing ones. One pending bit is not sticky: it follows a status line from the extended audio interrupt logic.

Top module: `audio_regport`

## Requirements
- R1: The pointer word (byte offset 0x00) holds the index in bits 27:16 and the channel in bits 1:0. All other bits read as zero. Each bit is written only when its byte enable is set, so a write that enables only byte 0 leaves the index unchanged, and a write that enables only bytes 2 and 3 leaves the channel unchanged.
- R2: The data word (byte offset 0x04) reads and writes the bank entry selected by the current (index, channel), one byte lane per byte enable. Different (index, channel) pairs are separate storage.
- R3: After reset the pointer, the pending word, the enable word and every implemented bank entry read as zero, and the interrupt request is low.
- R4: Writing the pending word (byte offset 0x08) clears every sticky bit where the written data is 1 and its byte lane is enabled. A 0 leaves the bit unchanged.
- R5: A high `evt_set` bit sets the pending bit at the same position, but only at the sticky positions 0, 1, 2, 3, 4, 11, 16 and 17. Event bits at any other position have no effect, and those positions read as zero.
- R6: Pending bit 8 shows, one clock later, the level of `ext_status_nz`. Host writes do not change it.
- R7: The enable word (byte offset 0x0C) is written by byte lane. It stores only the positions that exist in the pending word, and reads zero elsewhere.
- R8: `irq` is high exactly while some bit is set in both the pending word and the enable word. With the default settings it follows the registers with no extra delay.
- R9: If an event and a host clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: Bank indexes at or above the implemented count (default 64, so 0x40 and up) read as zero, and writes to them change no entry.
- R11: Each read request returns its data, with `host_rvalid` high, in the cycle after the request. `host_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | OFS_W | Byte offset of the host word |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables for the write |
| host_rdata | output | 32 | Read data, registered |
| host_rvalid | output | 1 | Read data valid |
| evt_set | input | 32 | One strobe per pending bit position |
| ext_status_nz | input | 1 | Extended audio interrupt status is nonzero |
| irq | output | 1 | Interrupt request |

## Verification
The pointer is written with full-word, low-byte-only and high-half-only enables, which shows whether its two fields are really independent. The bank is written at the first and last index and at several channels of the same index, then read back. This separates correct (index, channel) decoding from aliasing. A write to index 0x40 is followed by a read of index 0, which catches truncation of the index. The pending logic is driven with an all-ones event vector, masked clear writes, a same-cycle set and clear, and toggles of the status line, so sticky, non-sticky and tied-off bit positions can each be told apart.

// File: rtl/regport_pkg.sv
package regport_pkg;

   // Word selector for the host-visible words (byte offset bits 3:2).
   typedef enum logic [1:0] {
      SEL_PTR  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_PEND = 2'd2,
      SEL_EN   = 2'd3
   } reg_sel_e;

   // Sticky event positions: bus error, UART-A tx/rx, two timers,
   // serial-peripheral done, UART-B tx/rx.
   localparam logic [31:0] EVT_BITS = 32'h0003_081F;

   // Position of the live extended-status bit.
   localparam int EXT_POS = 8;

   // Expand four byte enables into a 32-bit lane mask.
   function automatic logic [31:0] lanes(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/regport_word.sv
module regport_word #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= (q & ~mask) | (wdata & mask);
   end

endmodule

// File: rtl/regport_ptr.sv
module regport_ptr #(
   parameter int CH_W = 2,
   parameter int AW   = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CH_W-1:0] ch_wd,
   input  logic [CH_W-1:0] ch_m,
   input  logic [AW-1:0]   adr_wd,
   input  logic [AW-1:0]   adr_m,
   output logic [CH_W-1:0] ch_q,
   output logic [AW-1:0]   adr_q
);

   // Each field is written bit by bit through its own lane mask, so
   // the two fields never disturb each other.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ch_q  <= '0;
         adr_q <= '0;
      end else if (we) begin
         ch_q  <= (ch_q & ~ch_m) | (ch_wd & ch_m);
         adr_q <= (adr_q & ~adr_m) | (adr_wd & adr_m);
      end
   end

endmodule

// File: rtl/regport_bank.sv
module regport_bank #(
   parameter int NUM_IDX = 64,
   parameter int CH_W    = 2,
   parameter int AW      = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   idx,
   input  logic [CH_W-1:0] ch,
   input  logic            we,
   input  logic [31:0]     mask,
   input  logic [31:0]     wdata,
   output logic [31:0]     rd
);

   localparam int IDX_W   = $clog2(NUM_IDX);
   localparam int FLAT_W  = IDX_W + CH_W;
   localparam int NUM_ENT = 1 << FLAT_W;

   if (NUM_IDX < 2 || (NUM_IDX & (NUM_IDX - 1)) != 0) begin : g_bad_idx
      $error("regport_bank: NUM_IDX must be a power of two, at least 2");
   end
   if (NUM_IDX >= (1 << AW)) begin : g_bad_aw
      $error("regport_bank: NUM_IDX must be below 2**AW");
   end

   logic              in_range;
   logic [FLAT_W-1:0] flat;
   logic [31:0]       words [NUM_ENT];

   assign in_range = (idx < AW'(NUM_IDX));
   assign flat     = {idx[IDX_W-1:0], ch};

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic hit;
      assign hit = we && in_range && (flat == FLAT_W'(e));
      regport_word #(.W(32)) i_word (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (hit),
         .mask  (mask),
         .wdata (wdata),
         .q     (words[e])
      );
   end

   assign rd = in_range ? words[flat] : '0;

endmodule

// File: rtl/regport_irq.sv
module regport_irq #(
   parameter logic [31:0] EVT_MASK = regport_pkg::EVT_BITS,
   parameter int          EXT_BIT  = regport_pkg::EXT_POS,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] evt,
   input  logic        ext_nz,
   input  logic        clr_we,
   input  logic        en_we,
   input  logic [31:0] mask,
   input  logic [31:0] wdata,
   output logic [31:0] pend_q,
   output logic [31:0] en_q,
   output logic        irq
);

   if (EXT_BIT < 0 || EXT_BIT > 31) begin : g_bad_ext
      $error("regport_irq: EXT_BIT out of range");
   end

   localparam logic [31:0] EXT_ONE = 32'(1) << EXT_BIT;
   localparam logic [31:0] STICKY  = EVT_MASK & ~EXT_ONE;
   localparam logic [31:0] IMPL    = STICKY | EXT_ONE;

   logic [31:0] clr;
   logic [31:0] pend_nx;
   logic [31:0] en_nx;
   logic        hit;

   assign clr = clr_we ? (wdata & mask) : '0;

   // Events are applied after the clear, so a same-cycle set wins.
   assign pend_nx = (((pend_q & ~clr) | evt) & STICKY)
                  | (ext_nz ? EXT_ONE : '0);

   assign en_nx = en_we ? (((en_q & ~mask) | (wdata & mask)) & IMPL) : en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
      end else begin
         pend_q <= pend_nx;
         en_q   <= en_nx;
      end
   end

   assign hit = |(pend_q & en_q);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= hit;
      end
   end else begin : g_irq_comb
      assign irq = hit;
   end

endmodule

// File: rtl/audio_regport.sv
module audio_regport #(
   parameter int          OFS_W    = 4,
   parameter int          CH_W     = 2,
   parameter int          AW       = 12,
   parameter int          A_LSB    = 16,
   parameter int          NUM_IDX  = 64,
   parameter logic [31:0] EVT_MASK = regport_pkg::EVT_BITS,
   parameter int          EXT_BIT  = regport_pkg::EXT_POS,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [OFS_W-1:0] host_addr,
   input  logic [31:0]      host_wdata,
   input  logic [3:0]       host_be,
   output logic [31:0]      host_rdata,
   output logic             host_rvalid,
   input  logic [31:0]      evt_set,
   input  logic             ext_status_nz,
   output logic             irq
);

   import regport_pkg::*;

   if (OFS_W < 4) begin : g_bad_ofs
      $error("audio_regport: OFS_W must be at least 4");
   end
   if (A_LSB + AW > 32 || CH_W > A_LSB) begin : g_bad_ptr
      $error("audio_regport: pointer fields overlap or overflow");
   end

   logic [OFS_W-1:0] word_ix;
   logic             in_map;
   reg_sel_e         sel;
   logic [31:0]      m;
   logic             we_ptr, we_data, we_pend, we_en;
   logic [CH_W-1:0]  ptr_ch;
   logic [AW-1:0]    ptr_adr;
   logic [31:0]      ptr_word;
   logic [31:0]      bank_rd;
   logic [31:0]      pend_q;
   logic [31:0]      en_q;
   logic [31:0]      rd_word;
   logic [31:0]      rdata_q;
   logic             rvalid_q;

   // Address decode: aligned words 0..3 only.
   assign word_ix = host_addr >> 2;
   assign in_map  = (host_addr[1:0] == 2'b00) && (word_ix < OFS_W'(4));
   assign sel     = reg_sel_e'(word_ix[1:0]);
   assign m       = lanes(host_be);

   assign we_ptr  = host_wr && in_map && (sel == SEL_PTR);
   assign we_data = host_wr && in_map && (sel == SEL_DATA);
   assign we_pend = host_wr && in_map && (sel == SEL_PEND);
   assign we_en   = host_wr && in_map && (sel == SEL_EN);

   regport_ptr #(.CH_W(CH_W), .AW(AW)) i_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we_ptr),
      .ch_wd  (host_wdata[CH_W-1:0]),
      .ch_m   (m[CH_W-1:0]),
      .adr_wd (host_wdata[A_LSB +: AW]),
      .adr_m  (m[A_LSB +: AW]),
      .ch_q   (ptr_ch),
      .adr_q  (ptr_adr)
   );

   always_comb begin
      ptr_word                 = '0;
      ptr_word[A_LSB +: AW]    = ptr_adr;
      ptr_word[CH_W-1:0]       = ptr_ch;
   end

   regport_bank #(.NUM_IDX(NUM_IDX), .CH_W(CH_W), .AW(AW)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (ptr_adr),
      .ch    (ptr_ch),
      .we    (we_data),
      .mask  (m),
      .wdata (host_wdata),
      .rd    (bank_rd)
   );

   regport_irq #(.EVT_MASK(EVT_MASK), .EXT_BIT(EXT_BIT), .IRQ_REG(IRQ_REG)) i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_set),
      .ext_nz (ext_status_nz),
      .clr_we (we_pend),
      .en_we  (we_en),
      .mask   (m),
      .wdata  (host_wdata),
      .pend_q (pend_q),
      .en_q   (en_q),
      .irq    (irq)
   );

   always_comb begin
      case (sel)
         SEL_PTR:  rd_word = ptr_word;
         SEL_DATA: rd_word = bank_rd;
         SEL_PEND: rd_word = pend_q;
         default:  rd_word = en_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= host_rd;
         if (host_rd)
            rdata_q <= in_map ? rd_word : '0;
      end
   end

   assign host_rdata  = rdata_q;
   assign host_rvalid = rvalid_q;

endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
   parameter int OFS_W   = 4,
   parameter int AW      = 12,
   parameter bit IRQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic             host_rd,
   input logic [OFS_W-1:0] host_addr,
   input logic             wd_b1,
   input logic [3:0]       host_be,
   input logic             host_rvalid,
   input logic             evt_b0,
   input logic             ext_status_nz,
   input logic             irq,
   input logic             pend_b0,
   input logic             pend_b1,
   input logic             pend_ext,
   input logic [31:0]      en_q,
   input logic [AW-1:0]    ptr_adr
);

   assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> host_rvalid);

   assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> !host_rvalid);

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_b0 |=> pend_b0);

   assert_ext_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pend_ext == $past(ext_status_nz)));

   assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_b1 && !(host_wr && host_addr == OFS_W'(8) && host_be[0] && wd_b1))
      |=> pend_b1);

   assert_ptr_ch_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == OFS_W'(0) && (host_be & 4'b1100) == 4'b0000)
      |=> $stable(ptr_adr));

   if (!IRQ_REG) begin : g_gate
      assert_en_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q == '0) |-> !irq);
   end

endmodule

bind audio_regport regport_chk #(.OFS_W(OFS_W), .AW(AW), .IRQ_REG(IRQ_REG)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_wr       (host_wr),
   .host_rd       (host_rd),
   .host_addr     (host_addr),
   .wd_b1         (host_wdata[1]),
   .host_be       (host_be),
   .host_rvalid   (host_rvalid),
   .evt_b0        (evt_set[0]),
   .ext_status_nz (ext_status_nz),
   .irq           (irq),
   .pend_b0       (pend_q[0]),
   .pend_b1       (pend_q[1]),
   .pend_ext      (pend_q[EXT_BIT]),
   .en_q          (en_q),
   .ptr_adr       (ptr_adr)
);

// File: tb/test_audio_regport.sv
module test_audio_regport;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_wr, host_rd;
   logic [3:0]  host_addr;
   logic [31:0] host_wdata;
   logic [3:0]  host_be;
   logic [31:0] host_rdata;
   logic        host_rvalid;
   logic [31:0] evt_set;
   logic        ext_status_nz;
   logic        irq;

   always #5 clk = ~clk;

   audio_regport i_audio_regport (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_wr       (host_wr),
      .host_rd       (host_rd),
      .host_addr     (host_addr),
      .host_wdata    (host_wdata),
      .host_be       (host_be),
      .host_rdata    (host_rdata),
      .host_rvalid   (host_rvalid),
      .evt_set       (evt_set),
      .ext_status_nz (ext_status_nz),
      .irq           (irq)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] q_exp [$];
   string       q_tag [$];
   logic [31:0] mem [64][4];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per returned read.
   always @(negedge clk) begin
      if (rst_n === 1'b1 && host_rvalid === 1'b1) begin
         if (q_exp.size() == 0)
            check("R11 unexpected rvalid", 32'd1, 32'd0);
         else
            check(q_tag.pop_front(), host_rdata, q_exp.pop_front());
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
      host_wr = 1'b1; host_addr = a; host_wdata = d; host_be = b;
      @(negedge clk);
      host_wr = 1'b0; host_be = 4'h0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      host_rd = 1'b1; host_addr = a;
      q_exp.push_back(exp); q_tag.push_back(tag);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] v);
      evt_set = v;
      @(negedge clk);
      evt_set = '0;
   endtask

   task automatic set_ptr(input int idx, input int ch);
      wr(4'h0, (32'(idx) << 16) | 32'(ch), 4'hF);
   endtask

   task automatic data_wr(input int idx, input int ch, input logic [31:0] d, input logic [3:0] b);
      logic [31:0] msk;
      set_ptr(idx, ch);
      wr(4'h4, d, b);
      msk = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
      if (idx < 64) mem[idx][ch] = (mem[idx][ch] & ~msk) | (d & msk);
   endtask

   task automatic data_rd(input int idx, input int ch, input string tag);
      set_ptr(idx, ch);
      rd(4'h4, (idx < 64) ? mem[idx][ch] : 32'h0, tag);
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog act=hung exp=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++)
         for (int j = 0; j < 4; j++)
            mem[i][j] = '0;
      rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_addr = '0;
      host_wdata = '0; host_be = '0; evt_set = '0; ext_status_nz = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: reset state
      check("R3 irq after reset", 32'(irq), 32'd0);
      rd(4'h0, 32'h0, "R3 pointer");
      rd(4'h8, 32'h0, "R3 pending");
      rd(4'hC, 32'h0, "R3 enable");
      data_rd(0, 0, "R3 bank 0/0");
      data_rd(63, 3, "R3 bank 63/3");

      // R1: pointer fields and byte lanes
      wr(4'h0, 32'hFFFF_FFFF, 4'hF);
      rd(4'h0, 32'h0FFF_0003, "R1 unused bits zero");
      wr(4'h0, 32'h0005_0001, 4'hF);
      wr(4'h0, 32'hFFFF_FFFE, 4'h1);
      rd(4'h0, 32'h0005_0002, "R1 channel-only write");
      wr(4'h0, 32'h0012_00FF, 4'hC);
      rd(4'h0, 32'h0012_0002, "R1 index-only write");

      // R2: bank access by (index, channel), byte lanes
      data_wr(5, 0, 32'h1111_1111, 4'hF);
      data_wr(5, 1, 32'h2222_2222, 4'hF);
      data_wr(63, 3, 32'hA5A5_5A5A, 4'hF);
      data_wr(0, 2, 32'h0BAD_F00D, 4'hF);
      data_wr(5, 1, 32'hCCDD_EEFF, 4'h5);
      data_rd(5, 0, "R2 idx5 ch0");
      data_rd(5, 1, "R2 idx5 ch1 partial lanes");
      data_rd(63, 3, "R2 idx63 ch3");
      data_rd(0, 2, "R2 idx0 ch2");
      data_rd(5, 2, "R2 idx5 ch2 untouched");

      // R10: unimplemented index
      data_wr(64, 2, 32'hDEAD_BEEF, 4'hF);
      data_rd(64, 2, "R10 idx 0x40 reads zero");
      data_rd(0, 2, "R10 idx0 not aliased");

      // R5: events, only sticky positions
      pulse(32'hFFFF_FFFF);
      rd(4'h8, 32'h0003_081F, "R5 event mask");

      // R4: write-one clear with lanes
      wr(4'h8, 32'h0000_0003, 4'hF);
      rd(4'h8, 32'h0003_081C, "R4 clear bits 1:0");
      wr(4'h8, 32'h0000_0000, 4'hF);
      rd(4'h8, 32'h0003_081C, "R4 zero write no effect");
      wr(4'h8, 32'hFFFF_FFFF, 4'h4);
      rd(4'h8, 32'h0000_081C, "R4 lane 2 clear only");

      // R7 and R8: enable and interrupt line
      wr(4'hC, 32'hFFFF_FFFF, 4'hF);
      rd(4'hC, 32'h0003_091F, "R7 enable implemented bits");
      check("R8 irq high with pend&en", 32'(irq), 32'd1);
      wr(4'hC, 32'h0000_0000, 4'hF);
      check("R8 irq low with en zero", 32'(irq), 32'd0);
      wr(4'h8, 32'hFFFF_FFFF, 4'hF);
      rd(4'h8, 32'h0, "R4 full clear");
      wr(4'hC, 32'h0000_0001, 4'hF);
      check("R8 irq low with no pending", 32'(irq), 32'd0);
      pulse(32'h0000_0001);
      check("R8 irq high after event", 32'(irq), 32'd1);

      // R9: same-cycle set and clear on bit 1
      evt_set = 32'h0000_0002;
      host_wr = 1'b1; host_addr = 4'h8; host_wdata = 32'h0000_0002; host_be = 4'hF;
      @(negedge clk);
      evt_set = '0; host_wr = 1'b0; host_be = 4'h0;
      rd(4'h8, 32'h0000_0003, "R9 set wins");

      // R6: live status bit
      ext_status_nz = 1'b1;
      @(negedge clk);
      wr(4'h8, 32'h0000_0100, 4'hF);
      rd(4'h8, 32'h0000_0103, "R6 status bit ignores clear");
      wr(4'hC, 32'h0000_0100, 4'hF);
      check("R8 irq from status bit", 32'(irq), 32'd1);
      ext_status_nz = 1'b0;
      @(negedge clk);
      check("R6 irq drops with status", 32'(irq), 32'd0);
      rd(4'h8, 32'h0000_0003, "R6 status bit follows low");

      repeat (3) @(negedge clk);
      check("R11 all reads returned", 32'(q_exp.size()), 32'd0);
      finish_run();
   end

endmodule